// File: doc/BRIEF.md
# UART Receive Path with Triggered Character FIFO

This block is the receive half of one asynchronous serial channel. It watches the serial input on a sixteen-times oversampling tick, rejects short low glitches, and gathers each character least significant bit first. It then checks the optional parity bit and the stop bit and writes the character into a 16-deep FIFO. Each FIFO entry keeps its own parity and framing flags, so an error is reported with the byte that caused it and not with some later byte.

The host side reads the oldest character whenever one is present. It removes that character with a one-cycle read pulse. A 2-bit trigger select sets how full the FIFO must be before the data-ready line rises. An active-low receive-ready output serves a DMA engine. In single-transfer mode it marks any stored character. In block mode it waits for the trigger level. Character length, parity mode, trigger select and DMA mode are static inputs, and they are changed only between characters. The serial input is expected to be already synchronous to `clk`.

Top module: `uart_rx_path`

## Requirements
- R1: A low input seen on a tick starts a frame candidate. The frame is accepted only if the input is still low on the 8th tick after that one (mid start bit). Otherwise the candidate is dropped and nothing is stored.
- R2: Data bits are sampled every 16 ticks after the start midpoint. The first received bit lands in bit 0. `char_len` 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, and the unused upper bits of `rd_data` read 0.
- R3: With `par_en`=1 one parity bit follows the data. `par_odd`=0 expects an even count of ones over data plus parity, and `par_odd`=1 expects an odd count. A mismatch sets that entry's `rd_perr`, and `rd_perr` is 0 when parity is off.
- R4: A stop bit sampled low sets that entry's `rd_ferr`, and the character is still stored.
- R5: Characters leave the FIFO in arrival order, 16 deep. While `rd_valid`=1, `rd_data`/`rd_perr`/`rd_ferr` show the oldest entry, and a cycle with `rd_en`=1 removes it.
- R6: `rd_en` while the FIFO is empty has no effect.
- R7: A character that arrives while all 16 entries are full and none is being read is dropped. It sets `overrun`, which stays 1 until reset, and the stored entries are unchanged.
- R8: `trig_sel` 0, 1, 2 or 3 sets the trigger level to 1, 4, 8 or 14 characters. `data_ready` is 1 exactly when the number of stored characters is at least that level.
- R9: With `dma_mode`=0, `rxrdy_n` is 0 exactly when at least one character is stored.
- R10: With `dma_mode`=1, `rxrdy_n` is 0 exactly when the stored count has reached the trigger level, and it is 1 while the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high, synchronous to clk |
| char_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| trig_sel | input | 2 | Trigger level select (1/4/8/14) |
| dma_mode | input | 1 | 0 = single transfer, 1 = block transfer |
| rd_en | input | 1 | Remove the oldest character |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity error flag of the oldest character |
| rd_ferr | output | 1 | Framing error flag of the oldest character |
| rd_valid | output | 1 | At least one character stored |
| data_ready | output | 1 | Stored count at or above trigger level |
| rxrdy_n | output | 1 | Active-low DMA receive-ready |
| overrun | output | 1 | Sticky overflow flag |

## Verification
On every cycle the assertions check the following. The FIFO count never exceeds its depth. An empty-FIFO read leaves the pointers alone. The overflow flag never falls. A write pulse comes only out of the stop-bit state. The start wait never runs past mid-bit. Both receive-ready modes agree with the stored count. The bench scenarios are needed for the parts an invariant cannot show: the bit order and length masking, the parity and framing flags on the right byte, rejection of a glitch, and the arrival order after an overflow. For these the bench drives serial frames and compares each byte read with its own model.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_char_t;

    // fill level at which the trigger fires for each select code
    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxp_sampler.sv
module rxp_sampler
    import rxp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    input  logic [1:0] char_len,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     push,
    output rx_char_t chr
);
    localparam int TW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    typedef struct packed {
        rx_state_e      st;
        logic [TW-1:0]  tcnt;
        logic [2:0]     bidx;
        logic [7:0]     shf;
        logic           perr;
        logic           push;
        rx_char_t       chr;
    } smp_t;

    smp_t q, d;
    logic [2:0] last_idx;

    always_comb begin
        d        = q;
        d.push   = 1'b0;
        last_idx = 3'd4 + {1'b0, char_len};
        if (tick) begin
            case (q.st)
                S_IDLE: begin
                    if (!rxd) begin
                        d.st   = S_START;
                        d.tcnt = '0;
                        d.bidx = '0;
                        d.shf  = '0;
                        d.perr = 1'b0;
                    end
                end
                S_START: begin
                    if (q.tcnt == TW'(MID - 1)) begin
                        d.tcnt = '0;
                        d.st   = rxd ? S_IDLE : S_DATA;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt        = '0;
                        d.shf[q.bidx] = rxd;
                        if (q.bidx == last_idx) begin
                            d.st = par_en ? S_PAR : S_STOP;
                        end else begin
                            d.bidx = q.bidx + 1'b1;
                        end
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt = '0;
                        d.perr = (^q.shf) ^ rxd ^ par_odd;
                        d.st   = S_STOP;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (q.tcnt == TW'(OVS - 1)) begin
                        d.tcnt     = '0;
                        d.push     = 1'b1;
                        d.chr.data = q.shf;
                        d.chr.perr = q.perr;
                        d.chr.ferr = ~rxd;
                        d.st       = S_IDLE;
                    end else begin
                        d.tcnt = q.tcnt + 1'b1;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push = q.push;
    assign chr  = q.chr;

    // R4: a character is only handed on at the end of the stop bit
    a_r4_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> $past(q.st) == S_STOP)
        else $error("push issued outside stop state");

    // R1: the start-bit wait never outlasts the midpoint
    a_r1_start_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_START) |-> (q.tcnt < TW'(MID)))
        else $error("start qualification ran past mid-bit");

endmodule

// File: rtl/rxp_fifo.sv
module rxp_fifo
    import rxp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  rx_char_t                  wr_chr,
    input  logic                      pop,
    output rx_char_t                  head,
    output logic [$clog2(DEPTH):0]    count,
    output logic                      overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wp;
        logic [AW-1:0]        rp;
        logic [CW-1:0]        cnt;
        logic                 ovr;
    } fifo_t;

    fifo_t q, d;
    logic do_pop, do_push, full;

    always_comb begin
        d       = q;
        full    = (q.cnt == CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        do_push = push && (!full || do_pop);
        if (do_push) begin
            d.mem[q.wp] = wr_chr;
            d.wp        = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        if (push && !do_push) begin
            d.ovr = 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head    = q.mem[q.rp];
    assign count   = q.cnt;
    assign overrun = q.ovr;

    // R7: occupancy never exceeds the depth
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH))
        else $error("fifo count above depth");

    // R7: overflow flag is sticky
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovr |=> q.ovr)
        else $error("overrun flag cleared without reset");

    // R6: reading an empty fifo changes nothing
    a_r6_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && q.cnt == '0) |=> (q.cnt == '0 && $stable(q.rp)))
        else $error("empty read disturbed the fifo");

endmodule

// File: rtl/rxp_trigger.sv
module rxp_trigger
    import rxp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] count,
    input  logic [1:0]             trig_sel,
    input  logic                   dma_mode,
    output logic                   data_ready,
    output logic                   rxrdy_n
);
    logic reached;

    always_comb begin
        reached    = (int'(count) >= int'(trig_level(trig_sel)));
        data_ready = reached;
        rxrdy_n    = dma_mode ? ~reached : (count == '0);
    end

    // R9: single-transfer mode tracks any stored character
    a_r9_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_mode && count != '0) |-> !rxrdy_n)
        else $error("single mode ready missing");

    // R10: block mode holds off while empty
    a_r10_block_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && count == '0) |-> rxrdy_n)
        else $error("block mode ready while empty");

    // R8: a full fifo is always at or above every trigger level
    a_r8_full_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == DEPTH) |-> data_ready)
        else $error("full fifo without data ready");

endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import rxp_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic [1:0] trig_sel,
    input  logic       dma_mode,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_valid,
    output logic       data_ready,
    output logic       rxrdy_n,
    output logic       overrun
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          push;
    rx_char_t      new_chr;
    rx_char_t      head;
    logic [CW-1:0] count;

    rxp_sampler #(.OVS(OVS)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .rxd      (rxd),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .push     (push),
        .chr      (new_chr)
    );

    rxp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wr_chr  (new_chr),
        .pop     (rd_en),
        .head    (head),
        .count   (count),
        .overrun (overrun)
    );

    rxp_trigger #(.DEPTH(DEPTH)) u_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .trig_sel   (trig_sel),
        .dma_mode   (dma_mode),
        .data_ready (data_ready),
        .rxrdy_n    (rxrdy_n)
    );

    assign rd_data  = head.data;
    assign rd_perr  = head.perr;
    assign rd_ferr  = head.ferr;
    assign rd_valid = (count != '0);

endmodule

// File: tb/uart_rx_path_test.sv
`timescale 1ns/1ps
module uart_rx_path_test;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick;
    logic       rxd = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       dma_mode = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_valid, data_ready, rxrdy_n, overrun;
    logic [1:0] tdiv = 2'd0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [9:0] exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign baud_tick = (tdiv == 2'd3);

    uart_rx_path uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
        .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
        .trig_sel(trig_sel), .dma_mode(dma_mode), .rd_en(rd_en),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr),
        .rd_valid(rd_valid), .data_ready(data_ready), .rxrdy_n(rxrdy_n),
        .overrun(overrun)
    );

    function automatic int exp_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] cl);
        return 8'hFF >> (3 - cl);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rxd   = 1'b1;
        rd_en = 1'b0;
        exp_q.delete();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (BITCLK) @(negedge clk);
    endtask

    // sends one frame and records the model entry; store=0 when it is expected to be dropped
    task automatic send_char(input logic [7:0] dat, input bit bad_par,
                             input bit stop_bit, input bit store);
        logic [7:0] m;
        logic       pbit;
        m    = dat & len_mask(char_len);
        pbit = (^m) ^ par_odd ^ bad_par;
        hold_bit(1'b0);
        for (int i = 0; i < 5 + int'(char_len); i++) hold_bit(dat[i]);
        if (par_en) hold_bit(pbit);
        hold_bit(stop_bit);
        hold_bit(1'b1);
        if (store) exp_q.push_back({m, par_en & bad_par, ~stop_bit});
    endtask

    task automatic read_check();
        logic [9:0] e;
        e = exp_q.pop_front();
        chk("R5 rd_valid before read", rd_valid, 1);
        chk("R2/R5 rd_data", rd_data, e[9:2]);
        chk("R3 rd_perr", rd_perr, e[1]);
        chk("R4 rd_ferr", rd_ferr, e[0]);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) read_check();
        chk("R5 empty after drain", rd_valid, 0);
    endtask

    task automatic check_levels(input int n);
        for (int s = 0; s < 4; s++) begin
            for (int md = 0; md < 2; md++) begin
                trig_sel = s[1:0];
                dma_mode = md[0];
                @(negedge clk);
                chk("R8 data_ready", data_ready, (n >= exp_level(s[1:0])) ? 1 : 0);
                if (md == 1)
                    chk("R10 block rxrdy_n", rxrdy_n, (n >= exp_level(s[1:0])) ? 0 : 1);
                else
                    chk("R9 single rxrdy_n", rxrdy_n, (n >= 1) ? 0 : 1);
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();

        // reset state
        chk("R5 reset rd_valid", rd_valid, 0);
        chk("R9 reset rxrdy_n", rxrdy_n, 1);
        chk("R8 reset data_ready", data_ready, 0);
        chk("R7 reset overrun", overrun, 0);

        // R2 eight data bits, no parity
        char_len = 2'd3; par_en = 1'b0;
        send_char(8'hA5, 0, 1, 1);
        read_check();
        // R2 short characters mask upper bits
        char_len = 2'd0; send_char(8'hFF, 0, 1, 1); read_check();
        char_len = 2'd1; send_char(8'hEA, 0, 1, 1); read_check();
        char_len = 2'd2; send_char(8'h93, 0, 1, 1); read_check();

        // R3 parity in both senses
        char_len = 2'd3; par_en = 1'b1;
        par_odd = 1'b0; send_char(8'h37, 0, 1, 1); send_char(8'h37, 1, 1, 1);
        par_odd = 1'b1; send_char(8'hC1, 0, 1, 1); send_char(8'hC1, 1, 1, 1);
        drain();
        par_en = 1'b0; par_odd = 1'b0;

        // R4 low stop bit
        send_char(8'h3C, 0, 0, 1);
        read_check();

        // R1 short low pulse is rejected
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
        chk("R1 glitch stores nothing", rd_valid, 0);
        send_char(8'h5A, 0, 1, 1);
        read_check();

        // R6 read on empty has no effect
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk);
        chk("R6 empty read rd_valid", rd_valid, 0);
        send_char(8'h81, 0, 1, 1);
        chk("R6 next char seen", rd_valid, 1);
        read_check();
        chk("R6 single entry only", rd_valid, 0);

        // R8/R9/R10 fill level sweep, then R7 overflow
        do_reset();
        check_levels(0);
        for (int k = 1; k <= 16; k++) begin
            send_char(8'($urandom), 0, 1, 1);
            check_levels(k);
        end
        chk("R7 no overrun at full", overrun, 0);
        send_char(8'h00, 0, 1, 0);
        chk("R7 overrun set", overrun, 1);
        dma_mode = 1'b0;
        drain();
        chk("R7 overrun sticky", overrun, 1);
        chk("R9 drained rxrdy_n", rxrdy_n, 1);
        do_reset();
        chk("R7 overrun cleared by reset", overrun, 0);

        // random frames
        for (int it = 0; it < 30; it++) begin
            char_len = 2'($urandom);
            par_en   = 1'($urandom);
            par_odd  = 1'($urandom);
            send_char(8'($urandom), ($urandom % 4) == 0, ($urandom % 6) != 0, 1);
            if (exp_q.size() >= 3 || ($urandom % 3) == 0) drain();
        end
        drain();

        finish_run();
    end

endmodule